// File: doc/BRIEF.md
# Quadrature and Pulse-Direction Edge Decoder

This block sits between two encoder inputs, A and B, and a downstream position counter. It decodes the inputs and emits one-cycle count-up and count-down strobes. The counter itself, its preset and any host access live elsewhere. A two-bit mode input chooses one of four count functions: pulse-direction counting, or quadrature decoding at single, double or quadruple resolution.

Both inputs come from outside the clock domain and pass through synchroniser chains before they are decoded. The block also drives a direction level. In quadrature modes it watches for samples in which A and B both change at once, which a clean Gray-coded encoder never produces, and raises a sticky noise-error flag when it sees one. A gate input suppresses the strobes without stopping direction tracking.

Top module: `quad_edge_decoder`

## Requirements
- R1: `mode` selects the count function: 2'b00 pulse-direction, 2'b01 quadrature x1, 2'b10 quadrature x2, 2'b11 quadrature x4.
- R2: In pulse-direction mode each rising edge of A gives exactly one strobe, up when B is high and down when B is low. Falling edges of A and all edges of B give none.
- R3: In x1 mode only A edges count. A rising edge while moving forward gives an up strobe, and a falling edge while moving backward gives a down strobe. The other A edges give nothing, so one full encoder cycle yields one strobe.
- R4: In x2 mode every legal edge of A gives one strobe in the current direction. Edges of B give none.
- R5: In x4 mode every legal edge of A or of B gives one strobe in the current direction.
- R6: Forward means A leads B, so the forward sequence of (A,B) is 00,10,11,01,00. `dir` is 1 for forward/up and 0 for backward/down. An up strobe is only ever seen with `dir` high and a down strobe with `dir` low. In pulse-direction mode `dir` follows B.
- R7: While `gate` is low, no strobe is produced, but `dir` still tracks the inputs.
- R8: In a quadrature mode, a sample in which A and B both change gives no strobe and sets `noise_err`. The flag then stays set through further legal motion until `err_clr` is pulsed.
- R9: A one-cycle `err_clr` pulse clears `noise_err` when no new illegal transition arrives in the same cycle.
- R10: `cnt_up` and `cnt_dn` are never high in the same cycle.
- R11: An input change made between two rising clock edges gives a strobe that is high for exactly the one cycle following the third rising edge after the change.
- R12: In pulse-direction mode, A and B changing together is not an error. A rising A still counts, with its direction taken from the new B.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enc_a | input | 1 | Encoder input A, asynchronous |
| enc_b | input | 1 | Encoder input B, asynchronous |
| mode | input | 2 | Count function select |
| gate | input | 1 | Strobe enable |
| err_clr | input | 1 | Clears the noise-error flag |
| cnt_up | output | 1 | One-cycle count-up strobe |
| cnt_dn | output | 1 | One-cycle count-down strobe |
| dir | output | 1 | Current direction, 1 = forward |
| noise_err | output | 1 | Sticky illegal-transition flag |

## Verification
The hardest case to reach from the ports is the illegal transition. A and B must change within the same sample after synchronisation, and the flag must then be shown to survive later legal motion. The stimulus changes both inputs in a single drive between clock edges, so both synchronisers capture the change on the same edge. It then runs a legal cycle before pulsing the clear. The same simultaneous change is repeated in pulse-direction mode to show that it counts there and raises no error.

// File: rtl/quad_edge_decoder.sv
module quad_edge_decoder #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enc_a,
  input  logic       enc_b,
  input  logic [1:0] mode,
  input  logic       gate,
  input  logic       err_clr,
  output logic       cnt_up,
  output logic       cnt_dn,
  output logic       dir,
  output logic       noise_err
);
  localparam logic [1:0] M_PD = 2'b00;
  localparam logic [1:0] M_X1 = 2'b01;
  localparam logic [1:0] M_X2 = 2'b10;
  localparam logic [1:0] M_X4 = 2'b11;
  localparam int TOP = SYNC_STAGES - 1;

  logic [TOP:0] sa, sb;
  logic a_q, b_q;
  logic a_s, b_s, a_chg, b_chg, single, fwd, bad, hit, up_c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sa  <= '0;
      sb  <= '0;
      a_q <= 1'b0;
      b_q <= 1'b0;
    end else begin
      sa  <= {sa[TOP-1:0], enc_a};
      sb  <= {sb[TOP-1:0], enc_b};
      a_q <= sa[TOP];
      b_q <= sb[TOP];
    end
  end

  assign a_s    = sa[TOP];
  assign b_s    = sb[TOP];
  assign a_chg  = a_s ^ a_q;
  assign b_chg  = b_s ^ b_q;
  assign single = a_chg ^ b_chg;
  assign fwd    = a_chg ? (a_s ^ b_q) : ~(b_s ^ a_q);
  assign bad    = (mode != M_PD) & a_chg & b_chg;

  always_comb begin
    hit  = 1'b0;
    up_c = fwd;
    case (mode)
      M_PD: begin
        hit  = a_chg & a_s;
        up_c = b_s;
      end
      M_X1: hit = a_chg & ~b_chg & (a_s == fwd);
      M_X2: hit = a_chg & ~b_chg;
      M_X4: hit = single;
      default: hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_up    <= 1'b0;
      cnt_dn    <= 1'b0;
      dir       <= 1'b1;
      noise_err <= 1'b0;
    end else begin
      cnt_up <= gate & hit & up_c;
      cnt_dn <= gate & hit & ~up_c;
      if (mode == M_PD)
        dir <= b_s;
      else if (single)
        dir <= fwd;
      if (bad)
        noise_err <= 1'b1;
      else if (err_clr)
        noise_err <= 1'b0;
    end
  end
endmodule

// File: rtl/quad_edge_decoder_chk.sv
module quad_edge_decoder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode,
  input logic       gate,
  input logic       err_clr,
  input logic       cnt_up,
  input logic       cnt_dn,
  input logic       dir,
  input logic       noise_err
);
  p_one_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(cnt_up && cnt_dn));

  p_gate_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !gate |=> (!cnt_up && !cnt_dn));

  p_up_dir_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_up |-> dir);

  p_dn_dir_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_dn |-> !dir);

  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (noise_err && !err_clr) |=> noise_err);

  p_err_quad_only_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00) |=> !$rose(noise_err));
endmodule

bind quad_edge_decoder quad_edge_decoder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .gate(gate), .err_clr(err_clr),
  .cnt_up(cnt_up), .cnt_dn(cnt_dn), .dir(dir), .noise_err(noise_err)
);

// File: tb/quad_edge_decoder_tb.sv
`timescale 1ns/1ps
module quad_edge_decoder_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enc_a = 1'b0, enc_b = 1'b0, gate = 1'b1, err_clr = 1'b0;
  logic [1:0] mode = 2'b00;
  logic cnt_up, cnt_dn, dir, noise_err;
  int total = 0, bad = 0, n_up = 0, n_dn = 0;
  bit done = 0;

  always #2 clk = ~clk;

  quad_edge_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b), .mode(mode),
    .gate(gate), .err_clr(err_clr), .cnt_up(cnt_up), .cnt_dn(cnt_dn),
    .dir(dir), .noise_err(noise_err)
  );

  always @(negedge clk) if (rst_n) begin
    if (cnt_up) n_up++;
    if (cnt_dn) n_dn++;
  end

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input logic a, input logic b);
    @(negedge clk);
    enc_a = a;
    enc_b = b;
    repeat (5) @(negedge clk);
  endtask

  task automatic fwd_cycle();
    step(1, 0); step(1, 1); step(0, 1); step(0, 0);
  endtask

  task automatic bwd_cycle();
    step(0, 1); step(1, 1); step(1, 0); step(0, 0);
  endtask

  task automatic t_reset();
    check("R1 reset up", cnt_up, 0);
    check("R1 reset dn", cnt_dn, 0);
    check("R8 reset err", noise_err, 0);
  endtask

  task automatic t_latency();
    mode = 2'b00; enc_b = 1'b1;
    repeat (5) @(negedge clk);
    enc_a = 1'b1;
    @(negedge clk); check("R11 edge1", cnt_up, 0);
    @(negedge clk); check("R11 edge2", cnt_up, 0);
    @(negedge clk); check("R11 edge3", cnt_up, 1);
    @(negedge clk); check("R11 edge4", cnt_up, 0);
    step(0, 0);
  endtask

  task automatic t_pd();
    int u0, d0;
    mode = 2'b00;
    u0 = n_up; d0 = n_dn;
    step(0, 1);
    for (int i = 0; i < 3; i++) begin step(1, 1); step(0, 1); end
    check("R2 pd up", n_up - u0, 3);
    check("R6 pd dir high", dir, 1);
    step(0, 0);
    for (int i = 0; i < 2; i++) begin step(1, 0); step(0, 0); end
    check("R2 pd down", n_dn - d0, 2);
    check("R2 pd no up from B", n_up - u0, 3);
    check("R6 pd dir low", dir, 0);
  endtask

  task automatic t_quad(input logic [1:0] m, input int per, input string req);
    int u0, d0;
    mode = m;
    u0 = n_up; d0 = n_dn;
    fwd_cycle(); fwd_cycle();
    check({req, " fwd up"}, n_up - u0, 2 * per);
    check({req, " fwd dn"}, n_dn - d0, 0);
    check("R6 dir fwd", dir, 1);
    u0 = n_up;
    bwd_cycle();
    check({req, " bwd dn"}, n_dn - d0, per);
    check({req, " bwd up"}, n_up - u0, 0);
    check("R6 dir bwd", dir, 0);
  endtask

  task automatic t_gate();
    int u0, d0;
    mode = 2'b11; gate = 1'b0;
    u0 = n_up; d0 = n_dn;
    fwd_cycle();
    check("R7 gated fwd", (n_up - u0) + (n_dn - d0), 0);
    check("R7 dir tracked fwd", dir, 1);
    bwd_cycle();
    check("R7 gated bwd", (n_up - u0) + (n_dn - d0), 0);
    check("R7 dir tracked bwd", dir, 0);
    gate = 1'b1;
  endtask

  task automatic t_noise();
    int u0, d0;
    mode = 2'b11;
    u0 = n_up; d0 = n_dn;
    step(1, 1);
    check("R8 err set", noise_err, 1);
    check("R8 no strobe", (n_up - u0) + (n_dn - d0), 0);
    step(0, 1); step(0, 0); fwd_cycle();
    check("R8 err sticky", noise_err, 1);
    @(negedge clk); err_clr = 1'b1;
    @(negedge clk); err_clr = 1'b0;
    check("R9 err cleared", noise_err, 0);
  endtask

  task automatic t_pd_both();
    int u0;
    mode = 2'b00;
    u0 = n_up;
    step(1, 1);
    check("R12 pd no err", noise_err, 0);
    check("R12 pd counts", n_up - u0, 1);
    step(0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_latency();
    t_pd();
    t_quad(2'b01, 1, "R3 x1");
    t_quad(2'b10, 2, "R4 x2");
    t_quad(2'b11, 4, "R5 x4");
    t_gate();
    t_noise();
    t_pd_both();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule